// File: doc/BRIEF.md
# UART Channel Status Word with Modem Change Latching

This block holds the status word of a single serial channel. It gathers the live levels of the four modem-control inputs (carrier detect, data set ready, clear to send, ring indicator), the receive-data-ready and transmit-empty conditions, and a sticky overrun flag. Alongside the levels it keeps one latched change flag per modem line, set whenever that line toggles in either direction.

All of these share one 32-bit word at fixed positions. Latched flags are cleared by writing a one to their position. Live level bits ignore writes. Host software can therefore read the word, act on it, and write the same value straight back. That clears exactly the events it has seen and leaves every level untouched.

The block also drives one channel request line. The request is raised when a pending condition is present and that condition's class is enabled. There are three classes: receive, transmit and modem-status. Modem inputs are asynchronous and pass through a synchroniser before edges are detected. The receive and transmit conditions arrive already synchronous to the clock.

Top module: `uart_chan_status`

## Requirements
- R1: After reset, with all inputs low, the status word reads zero and the channel request is low.
- R2: Modem line levels appear at bit 3 (carrier detect), bit 4 (data set ready), bit 5 (clear to send) and bit 6 (ring indicator). A level appears two clock edges after the input changes.
- R3: Bit 0 follows the receive-data-ready input and bit 25 follows the transmit-empty input, with no latency.
- R4: Each modem line has a latched change flag: bit 16 for data set ready, bit 17 for clear to send, bit 18 for carrier detect and bit 22 for ring indicator. The flag is set on a rising or a falling edge of its line, one clock edge after the level bit has updated.
- R5: Writing a one to a change flag's position clears it. Writing a zero to that position leaves it unchanged.
- R6: Writes have no effect on the level bits or on bits 0 and 25. Writing back a value just read clears only the latched flags that were set in it.
- R7: If a new edge of a line is detected on the same clock edge as a write that clears that line's change flag, the flag remains set.
- R8: Bit 13 is a sticky overrun flag. It is set on any clock edge where the overrun input is high and cleared by writing a one to bit 13. If the input is high on the edge where the clear is written, the flag stays set.
- R9: The channel request is high exactly when at least one of these holds: bit 0 is set and receive requests are enabled; bit 25 is set and transmit requests are enabled; any change flag is set and modem-status requests are enabled.
- R10: Every bit position not listed above reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| modem_in | input | 4 | Asynchronous modem lines: [0] carrier detect, [1] data set ready, [2] clear to send, [3] ring indicator |
| rx_ready | input | 1 | Receive data is available |
| rx_overrun | input | 1 | Receive overrun pulse |
| tx_empty | input | 1 | Transmit path is empty |
| ms_irq_en | input | 1 | Enable for modem-status requests |
| rx_irq_en | input | 1 | Enable for receive requests |
| tx_irq_en | input | 1 | Enable for transmit requests |
| wr_en | input | 1 | Write strobe for the status word |
| wr_data | input | 32 | Write data; ones clear latched flags |
| rd_data | output | 32 | Current status word |
| chan_irq | output | 1 | Channel request |

## Verification
The hardest case to reach is a clear write that lands on the same clock edge as a freshly detected edge of the same line. The detection edge trails the input change by the depth of the synchroniser plus one register. The stimulus first clears the flag and then toggles the line. It waits exactly two edges and then issues the clear write, so the write strobe is sampled on the detection edge. Overrun gets the matching treatment: the input is held high across its own clear write.

// File: rtl/chan_stat_pkg.sv
package chan_stat_pkg;

   localparam int unsigned STAT_W   = 32;
   localparam int unsigned N_LINES  = 4;

   // status word positions (software decodes these)
   localparam int unsigned POS_RXRDY   = 0;
   localparam int unsigned POS_OVR     = 13;
   localparam int unsigned POS_TXE     = 25;

   typedef enum logic [1:0] {
      LN_DCD = 2'd0,
      LN_DSR = 2'd1,
      LN_CTS = 2'd2,
      LN_RI  = 2'd3
   } line_e;

   function automatic int unsigned level_pos(input int unsigned ln);
      case (ln)
         0:       return 3;
         1:       return 4;
         2:       return 5;
         default: return 6;
      endcase
   endfunction

   function automatic int unsigned change_pos(input int unsigned ln);
      case (ln)
         0:       return 18;
         1:       return 16;
         2:       return 17;
         default: return 22;
      endcase
   endfunction

endpackage

// File: rtl/line_sync.sv
module line_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("line_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("line_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) chain[i] <= '0;
      end else begin
         chain[0] <= din;
         for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
      end
   end

   assign dout = chain[STAGES-1];

   // R2: last stage is the previous stage delayed by one edge
   p_sync_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dout == $past(chain[STAGES-2]));

endmodule

// File: rtl/edge_latch.sv
module edge_latch #(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl,
   input  logic [WIDTH-1:0] clr,
   output logic [WIDTH-1:0] chg
);

   if (WIDTH < 1) begin : g_bad_width
      $error("edge_latch: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] prev_q;
   logic [WIDTH-1:0] edge_det;

   assign edge_det = lvl ^ prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         chg    <= '0;
      end else begin
         prev_q <= lvl;
         chg    <= (chg & ~clr) | edge_det;
      end
   end

   for (genvar g = 0; g < int'(WIDTH); g++) begin : g_chk
      // R4: a detected edge always leaves the flag set
      p_set_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (lvl[g] != prev_q[g]) |=> chg[g]);
      // R5: a clear with no competing edge drops the flag
      p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[g] && (lvl[g] == prev_q[g])) |=> !chg[g]);
      // R5: without a clear a set flag persists
      p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (chg[g] && !clr[g]) |=> chg[g]);
      // R7: edge and clear together keep the flag
      p_edge_beats_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[g] && (lvl[g] != prev_q[g])) |=> chg[g]);
   end

endmodule

// File: rtl/uart_chan_status.sv
module uart_chan_status
   import chan_stat_pkg::*;
#(
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned WORD_W        = STAT_W,
   parameter bit          LATCH_OVERRUN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        modem_in,
   input  logic              rx_ready,
   input  logic              rx_overrun,
   input  logic              tx_empty,
   input  logic              ms_irq_en,
   input  logic              rx_irq_en,
   input  logic              tx_irq_en,
   input  logic              wr_en,
   input  logic [31:0]       wr_data,
   output logic [31:0]       rd_data,
   output logic              chan_irq
);

   localparam int unsigned NL = N_LINES;

   if (WORD_W != 32) begin : g_bad_word
      $error("uart_chan_status: WORD_W must be 32");
   end

   logic [NL-1:0] lvl_sync;
   logic [NL-1:0] chg;
   logic [NL-1:0] chg_clr;
   logic          ovr_flag;
   logic          ovr_clr;

   line_sync #(.WIDTH(NL), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (modem_in),
      .dout  (lvl_sync)
   );

   for (genvar g = 0; g < int'(NL); g++) begin : g_clr
      assign chg_clr[g] = wr_en & wr_data[change_pos(g)];
   end

   edge_latch #(.WIDTH(NL)) u_chg (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (lvl_sync),
      .clr   (chg_clr),
      .chg   (chg)
   );

   assign ovr_clr = wr_en & wr_data[POS_OVR];

   if (LATCH_OVERRUN) begin : g_ovr_sticky
      logic ovr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ovr_q <= 1'b0;
         else        ovr_q <= (ovr_q & ~ovr_clr) | rx_overrun;
      end
      assign ovr_flag = ovr_q;
      // R8: overrun input always lands in the sticky flag
      p_ovr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
         rx_overrun |=> rd_data[POS_OVR]);
   end else begin : g_ovr_live
      assign ovr_flag = rx_overrun;
   end

   always_comb begin
      rd_data = '0;
      rd_data[POS_RXRDY] = rx_ready;
      rd_data[POS_TXE]   = tx_empty;
      rd_data[POS_OVR]   = ovr_flag;
      for (int i = 0; i < int'(NL); i++) begin
         rd_data[level_pos(i)]  = lvl_sync[i];
         rd_data[change_pos(i)] = chg[i];
      end
   end

   assign chan_irq = (rx_ready & rx_irq_en)
                   | (tx_empty & tx_irq_en)
                   | ((|chg) & ms_irq_en);

   // R9: enabled receive condition forces a request
   p_irq_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[POS_RXRDY] && rx_irq_en) |-> chan_irq);
   // R9: a quiet request implies no enabled pending change
   p_irq_ms_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_irq |-> !(ms_irq_en && (rd_data[22:16] != '0)));

endmodule

// File: tb/uart_chan_status_bench.sv
module uart_chan_status_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  modem_in = '0;
   logic        rx_ready = 1'b0, rx_overrun = 1'b0, tx_empty = 1'b0;
   logic        ms_irq_en = 1'b0, rx_irq_en = 1'b0, tx_irq_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        chan_irq;

   always #2.5 clk = ~clk;

   uart_chan_status u_uart_chan_status (
      .clk(clk), .rst_n(rst_n), .modem_in(modem_in),
      .rx_ready(rx_ready), .rx_overrun(rx_overrun), .tx_empty(tx_empty),
      .ms_irq_en(ms_irq_en), .rx_irq_en(rx_irq_en), .tx_irq_en(tx_irq_en),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .chan_irq(chan_irq)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   string       q_tag [$];
   logic [31:0] q_word [$];
   logic        q_irq [$];

   // bench model state: [0] carrier, [1] set ready, [2] clear to send, [3] ring
   logic [3:0] m_lvl = '0;
   logic [3:0] m_chg = '0;
   logic       m_ovr = 1'b0;

   function automatic logic [31:0] model_word();
      logic [31:0] w = '0;
      w[0]  = rx_ready;
      w[25] = tx_empty;
      w[13] = m_ovr;
      w[3]  = m_lvl[0];
      w[4]  = m_lvl[1];
      w[5]  = m_lvl[2];
      w[6]  = m_lvl[3];
      w[18] = m_chg[0];
      w[16] = m_chg[1];
      w[17] = m_chg[2];
      w[22] = m_chg[3];
      return w;
   endfunction

   function automatic logic model_irq();
      return (rx_ready && rx_irq_en) || (tx_empty && tx_irq_en) ||
             ((m_chg != 0) && ms_irq_en);
   endfunction

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic expect_now(input string tag);
      q_tag.push_back(tag);
      q_word.push_back(model_word());
      q_irq.push_back(model_irq());
      @(negedge clk);
      #1;
   endtask

   task automatic write_word(input logic [31:0] d);
      wr_data = d;
      wr_en   = 1'b1;
      step(1);
      wr_en   = 1'b0;
      wr_data = '0;
   endtask

   // monitor: pops one expected item per falling edge
   always @(negedge clk) begin
      if (q_tag.size() > 0) begin
         string tg;
         logic [31:0] ew;
         logic ei;
         tg = q_tag.pop_front();
         ew = q_word.pop_front();
         ei = q_irq.pop_front();
         n_cmp++;
         if (rd_data !== ew || chan_irq !== ei) begin
            n_bad++;
            $display("FAIL %s: word=%h irq=%b expected word=%h irq=%b",
                     tg, rd_data, chan_irq, ew, ei);
         end
      end
   end

   initial begin
      #400000;
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      expect_now("R1 reset word zero");

      // R3 live bits, R9 request enables
      rx_ready = 1'b1;
      expect_now("R3 rx ready bit0 no enable");
      rx_irq_en = 1'b1;
      expect_now("R9 rx request");
      rx_ready = 1'b0; tx_empty = 1'b1;
      expect_now("R3 tx empty bit25");
      tx_irq_en = 1'b1;
      expect_now("R9 tx request");
      tx_empty = 1'b0; rx_irq_en = 1'b0; tx_irq_en = 1'b0;

      // R2 level latency, R4 change flag on rising edge
      modem_in[0] = 1'b1;
      step(2);
      m_lvl[0] = 1'b1;
      expect_now("R2 carrier level after two edges");
      step(0);
      // expect_now consumed one more edge: flag set now
      m_chg[0] = 1'b1;
      expect_now("R4 carrier change flag bit18");
      ms_irq_en = 1'b1;
      expect_now("R9 modem request");

      // R4 falling edge on ring indicator (pulse)
      modem_in[3] = 1'b1;
      step(3);
      m_lvl[3] = 1'b1; m_chg[3] = 1'b1;
      expect_now("R4 ring rising");
      write_word(32'h0040_0000);
      m_chg[3] = 1'b0;
      expect_now("R5 ring flag cleared");
      modem_in[3] = 1'b0;
      step(3);
      m_lvl[3] = 1'b0; m_chg[3] = 1'b1;
      expect_now("R4 ring falling edge sets flag");

      // R5 zero write leaves flags
      write_word(32'h0000_0000);
      expect_now("R5 zero write no clear");

      // R6 read-back clear with clear-to-send level high
      modem_in[2] = 1'b1;
      step(3);
      m_lvl[2] = 1'b1; m_chg[2] = 1'b1;
      expect_now("R6 pre write-back");
      write_word(rd_data);
      m_chg = '0;
      expect_now("R6 write-back clears events only");
      write_word(32'hFFFF_FFFF);
      expect_now("R6 all-ones write keeps levels");

      // R7 clear coincides with detected edge
      modem_in[1] = 1'b1;
      step(2);
      write_word(32'h0001_0000);
      m_lvl[1] = 1'b1; m_chg[1] = 1'b1;
      expect_now("R7 edge wins over clear");
      write_word(32'h0001_0000);
      m_chg[1] = 1'b0;
      expect_now("R5 set-ready flag cleared later");
      ms_irq_en = 1'b0;

      // R8 overrun sticky
      rx_overrun = 1'b1;
      step(1);
      rx_overrun = 1'b0;
      m_ovr = 1'b1;
      expect_now("R8 overrun set");
      step(2);
      expect_now("R8 overrun sticky");
      write_word(32'h0000_2000);
      m_ovr = 1'b0;
      expect_now("R8 overrun cleared");
      rx_overrun = 1'b1;
      write_word(32'h0000_2000);
      rx_overrun = 1'b0;
      m_ovr = 1'b1;
      expect_now("R8 overrun input beats clear");
      write_word(32'h0000_2000);
      m_ovr = 1'b0;
      expect_now("R10 unused bits zero after clears");

      step(2);
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule